// File: doc/BRIEF.md
# Serial Data/Control Frame Port

This block is the device end of a synchronous serial link that a host uses to exchange 16-bit sample words with a codec-style front end. Every frame is framed by a one-clock frame-sync pulse. The sixteen bits that follow are sampled from `sdin` on rising edges of the serial clock, while `sdout` is driven on falling edges. Both directions are shifted most significant bit first. In a data frame the port returns the receive code word taken from `rx_code` and delivers the host's transmit word on `tx_code`.

Control frames fall between data frames and give access to a small byte-wide register file with a 7-bit address. Register 01h sets the mode. In software mode (bit 0 clear), bit 0 of each incoming data word asks for one control frame, and that bit is cleared in the delivered sample. In hardware mode (bit 0 set), all sixteen bits are sample data, and a control frame is due after every data frame. An external frame scheduler reads `ctl_frame_due` and the two mode outputs to decide when to issue the next frame-sync pulse.

Top module: `sfp_port`

## Requirements
- R1: The rising edge that sees `fsync` high is followed by 16 rising edges that sample `sdin` bits 15 down to 0. During a data frame, `sdout` carries the `rx_code` value captured at the `fsync` edge, bit 15 first, one bit per clock.
- R2: At the rising edge that samples bit 0 of a data frame, `tx_code` updates and `tx_code_stb` goes high for exactly one clock. Control frames leave both unchanged.
- R3: With register 01h bit 0 at 0, `tx_code` bit 0 is delivered as 0. The sampled `sdin` bit 0 sets `ctl_frame_due` when it is 1 and clears it when it is 0.
- R4: With register 01h bit 0 at 1, `tx_code` equals all 16 received bits, and `ctl_frame_due` is set after every data frame.
- R5: A frame is a control frame exactly when `ctl_frame_due` is 1 at its `fsync` edge. A completed control frame clears `ctl_frame_due`, so two control frames never run back to back.
- R6: A control word carries read/write in bit 15 (0 = write), the address in bits 14:8 and the write byte in bits 7:0. A write stores the byte at the addressed register, and `sdout` stays 0 for all 16 bits.
- R7: On a read (bit 15 = 1), no register changes. `sdout` sends eight zero bits and then the addressed register byte, MSB first.
- R8: Only addresses 00h–07h exist. Writes to 08h–7Fh change no register, and reads from them return 0x00.
- R9: Reset (synchronous, active-low) clears all registers, `tx_code`, `tx_code_stb` and `ctl_frame_due`, so the first frame is a data frame. `hw_ctl_mode` and `ctl_quarter_pos` show register 01h bits 0 and 1.
- R10: `sdout` changes only on falling edges of `sclk`, and it is 0 outside frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync | input | 1 | One-clock frame-sync pulse preceding bit 15 |
| sdin | input | 1 | Serial input from host |
| sdout | output | 1 | Serial output to host |
| rx_code | input | 16 | Receive code word sent in the next data frame |
| tx_code | output | 16 | Last transmit code word received |
| tx_code_stb | output | 1 | One-clock pulse when tx_code updates |
| ctl_frame_due | output | 1 | Next frame will be treated as a control frame |
| hw_ctl_mode | output | 1 | Register 01h bit 0: hardware control mode |
| ctl_quarter_pos | output | 1 | Register 01h bit 1: control frame placement hint |

## Verification
If the stored frame kind is wrong, the very next frame shows the fault. A data word then comes back as zeros plus a register byte, or a register read comes back as sample data. A bad bit counter puts `sdout` a bit early or late and shifts `tx_code`, so the fault shows in the first frame after it occurs. A corrupt register byte stays hidden until that address is read back, or until register 01h changes the mode outputs and the handling of `tx_code` bit 0. For this reason the bench reads registers back after every write, and checks `sdout` both before and after every falling edge.

// File: rtl/sfp_pkg.sv
// Shared constants and types for the serial frame port.
// Assumes a single serial clock domain for the whole port.
package sfp_pkg;
    localparam int SFP_WORD_W = 16;
    localparam int SFP_ADDR_W = 7;
    localparam int SFP_DATA_W = 8;
    localparam int SFP_NREGS  = 8;

    typedef enum logic {
        FRM_DATA = 1'b0,
        FRM_CTRL = 1'b1
    } frame_kind_e;
endpackage

// File: rtl/sfp_deser.sv
// Input deserializer: counts the bits of one frame after the sync pulse and
// shifts sdin in MSB first on rising edges. Assumes a new sync pulse
// restarts the frame.
module sfp_deser #(
    parameter int WORD_W = sfp_pkg::SFP_WORD_W,
    parameter int HEAD_W = sfp_pkg::SFP_ADDR_W,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic              sdin,
    output logic              active,
    output logic [CNT_W-1:0]  bit_idx,
    output logic              word_done,
    output logic [WORD_W-1:0] word_full,
    output logic [HEAD_W-1:0] head_bits
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [WORD_W-2:0] shift_q;

    // Frame bit counter and shift register.
    always_ff @(posedge sclk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            bit_idx <= '0;
            shift_q <= '0;
        end else if (fsync) begin
            active  <= 1'b1;
            bit_idx <= '0;
        end else if (active) begin
            shift_q <= {shift_q[WORD_W-3:0], sdin};
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == LAST) begin
                active <= 1'b0;
            end
        end
    end

    // Completed word including the bit on the pins at this edge.
    always_comb begin
        word_done = active && !fsync && (bit_idx == LAST);
        word_full = {shift_q, sdin};
        head_bits = shift_q[HEAD_W-1:0];
    end

    // R1
    frame_start_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        $rose(active) |-> $past(fsync));
endmodule

// File: rtl/sfp_regfile.sv
// Byte-wide register file for control frames. Only NREGS low addresses
// exist: writes above them are dropped and reads return zero. Register 1
// bits 0 and 1 are brought out as mode outputs.
module sfp_regfile #(
    parameter int ADDR_W = sfp_pkg::SFP_ADDR_W,
    parameter int DATA_W = sfp_pkg::SFP_DATA_W,
    parameter int NREGS  = sfp_pkg::SFP_NREGS,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              cfg_hc,
    output logic              cfg_pos
);
    logic [NREGS-1:0][DATA_W-1:0] regs;

    // Register storage with an address-range qualified write.
    always_ff @(posedge sclk) begin
        if (!rst_n) begin
            regs <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NREGS; i++) begin
                if (wr_addr == ADDR_W'(i)) begin
                    regs[i] <= wr_data;
                end
            end
        end
    end

    // Read mux returning zero above the implemented range.
    always_comb begin
        if (rd_addr < ADDR_W'(NREGS)) begin
            rd_data = regs[rd_addr[IDX_W-1:0]];
        end else begin
            rd_data = '0;
        end
        cfg_hc  = regs[1][0];
        cfg_pos = regs[1][1];
    end

    // R8
    unimpl_write_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (wr_en && (wr_addr >= ADDR_W'(NREGS))) |=> $stable(regs));
    // R9
    mode_write_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (wr_en && (wr_addr == ADDR_W'(1))) |=> (cfg_hc == $past(wr_data[0])
                                               && cfg_pos == $past(wr_data[1])));
endmodule

// File: rtl/sfp_ser.sv
// Output serializer. Loads the outgoing word at the sync edge and patches in
// the register byte once a control header is known. It then drives sdout on
// falling edges so that the host samples a stable bit on the next rising edge.
module sfp_ser #(
    parameter int WORD_W = sfp_pkg::SFP_WORD_W,
    parameter int DATA_W = sfp_pkg::SFP_DATA_W,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic              load_ctrl,
    input  logic [WORD_W-1:0] rx_code,
    input  logic              active,
    input  logic [CNT_W-1:0]  bit_idx,
    input  logic              rd_phase,
    input  logic              rd_is_read,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sdout
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] out_word;
    logic              next_bit;

    // Outgoing word: sample at sync, register byte after the header.
    always_ff @(posedge sclk) begin
        if (!rst_n) begin
            out_word <= '0;
        end else if (fsync) begin
            out_word <= load_ctrl ? '0 : rx_code;
        end else if (rd_phase) begin
            out_word[DATA_W-1:0] <= rd_is_read ? rd_data : '0;
        end
    end

    // Bit selected for the current position, zero when idle.
    always_comb begin
        next_bit = active ? out_word[LAST - bit_idx] : 1'b0;
    end

    // Falling-edge output register.
    always_ff @(negedge sclk) begin
        if (!rst_n) begin
            sdout <= 1'b0;
        end else begin
            sdout <= next_bit;
        end
    end

    // R10
    idle_low_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (!active && !$past(active)) |-> !sdout);
endmodule

// File: rtl/sfp_port.sv
// Top of the serial data/control frame port. Decides whether each frame is a
// data or control frame, delivers transmit samples, and executes register
// reads and writes. Frame timing (fsync) comes from an external scheduler.
module sfp_port #(
    parameter int WORD_W = sfp_pkg::SFP_WORD_W,
    parameter int ADDR_W = sfp_pkg::SFP_ADDR_W,
    parameter int DATA_W = sfp_pkg::SFP_DATA_W,
    parameter int NREGS  = sfp_pkg::SFP_NREGS
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic              sdin,
    output logic              sdout,
    input  logic [WORD_W-1:0] rx_code,
    output logic [WORD_W-1:0] tx_code,
    output logic              tx_code_stb,
    output logic              ctl_frame_due,
    output logic              hw_ctl_mode,
    output logic              ctl_quarter_pos
);
    import sfp_pkg::*;
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(ADDR_W);

    logic              active;
    logic [CNT_W-1:0]  bit_idx;
    logic              word_done;
    logic [WORD_W-1:0] word_full;
    logic [ADDR_W-1:0] head_bits;
    frame_kind_e       frame_q;
    logic              due_q;
    logic              last_ctrl_q;
    logic              wr_en;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_phase;
    logic              rd_is_read;
    logic [DATA_W-1:0] rd_data;

    sfp_deser #(.WORD_W(WORD_W), .HEAD_W(ADDR_W)) u_deser (
        .sclk(sclk), .rst_n(rst_n), .fsync(fsync), .sdin(sdin),
        .active(active), .bit_idx(bit_idx), .word_done(word_done),
        .word_full(word_full), .head_bits(head_bits)
    );

    // Control word decode and header lookup.
    always_comb begin
        wr_en      = word_done && (frame_q == FRM_CTRL) && !word_full[WORD_W-1];
        rd_addr    = {head_bits[ADDR_W-2:0], sdin};
        rd_is_read = head_bits[ADDR_W-1];
        rd_phase   = active && !fsync && (frame_q == FRM_CTRL) && (bit_idx == HDR_LAST);
    end

    sfp_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREGS(NREGS)) u_regs (
        .sclk(sclk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_addr(word_full[WORD_W-2 -: ADDR_W]), .wr_data(word_full[DATA_W-1:0]),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .cfg_hc(hw_ctl_mode), .cfg_pos(ctl_quarter_pos)
    );

    sfp_ser #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_ser (
        .sclk(sclk), .rst_n(rst_n), .fsync(fsync), .load_ctrl(due_q),
        .rx_code(rx_code), .active(active), .bit_idx(bit_idx),
        .rd_phase(rd_phase), .rd_is_read(rd_is_read), .rd_data(rd_data),
        .sdout(sdout)
    );

    // Frame kind, control request tracking and sample delivery.
    always_ff @(posedge sclk) begin
        if (!rst_n) begin
            frame_q     <= FRM_DATA;
            due_q       <= 1'b0;
            last_ctrl_q <= 1'b0;
            tx_code     <= '0;
            tx_code_stb <= 1'b0;
        end else begin
            tx_code_stb <= 1'b0;
            if (fsync) begin
                frame_q <= due_q ? FRM_CTRL : FRM_DATA;
            end
            if (word_done) begin
                if (frame_q == FRM_DATA) begin
                    tx_code     <= hw_ctl_mode ? word_full : {word_full[WORD_W-1:1], 1'b0};
                    tx_code_stb <= 1'b1;
                    due_q       <= hw_ctl_mode | word_full[0];
                    last_ctrl_q <= 1'b0;
                end else begin
                    due_q       <= 1'b0;
                    last_ctrl_q <= 1'b1;
                end
            end
        end
    end

    always_comb ctl_frame_due = due_q;

    // R2
    stb_single_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        tx_code_stb |=> !tx_code_stb);
    // R3
    sw_lsb_clear_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (tx_code_stb && !hw_ctl_mode) |-> !tx_code[0]);
    // R4
    hw_due_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (tx_code_stb && hw_ctl_mode) |-> ctl_frame_due);
    // R5
    no_double_ctrl_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (fsync && ctl_frame_due) |-> !last_ctrl_q);
    // R6
    ctrl_high_zero_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (active && frame_q == FRM_CTRL && bit_idx <= HDR_LAST) |-> !sdout);
endmodule

// File: tb/sfp_port_test.sv
// Bench for sfp_port: behavioural model of register file, mode and request
// state; every serial bit is compared before and after the falling edge.
module sfp_port_test;
    logic        sclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fsync = 1'b0;
    logic        sdin = 1'b0;
    logic        sdout;
    logic [15:0] rx_code = '0;
    logic [15:0] tx_code;
    logic        tx_code_stb;
    logic        ctl_frame_due;
    logic        hw_ctl_mode;
    logic        ctl_quarter_pos;

    int tests = 0;
    int fails = 0;

    logic [7:0]  m_regs [8];
    logic        m_due = 1'b0;
    logic [15:0] m_tx = '0;

    always #2 sclk = ~sclk;

    sfp_port uut (
        .sclk(sclk), .rst_n(rst_n), .fsync(fsync), .sdin(sdin), .sdout(sdout),
        .rx_code(rx_code), .tx_code(tx_code), .tx_code_stb(tx_code_stb),
        .ctl_frame_due(ctl_frame_due), .hw_ctl_mode(hw_ctl_mode),
        .ctl_quarter_pos(ctl_quarter_pos)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One frame; kind, expected sdout word and results come from the model.
    task automatic frame(input logic [15:0] w, input logic [15:0] rxw);
        logic        is_ctrl = m_due;
        logic        hc = m_regs[1][0];
        logic [15:0] exp_out;
        logic [6:0]  addr = w[14:8];
        logic        exp_stb;
        if (!is_ctrl) exp_out = rxw;                           // R1
        else if (w[15]) exp_out = {8'h00, (addr < 7'd8) ? m_regs[addr[2:0]] : 8'h00}; // R7 R8
        else exp_out = 16'h0000;                               // R6
        fsync = 1'b1; rx_code = rxw;
        @(posedge sclk); #1;
        fsync = 1'b0; rx_code = ~rxw;
        check("R10 hold before first bit", {15'd0, sdout}, 16'd0);
        sdin = w[15];
        #2 check(is_ctrl ? "R6/R7 ctrl sdout bit" : "R1 data sdout bit", {15'd0, sdout}, {15'd0, exp_out[15]});
        for (int i = 14; i >= 0; i--) begin
            @(posedge sclk); #1;
            check("R10 sdout stable until falling edge", {15'd0, sdout}, {15'd0, exp_out[i+1]});
            sdin = w[i];
            #2 check(is_ctrl ? "R7 ctrl sdout bit" : "R1 data sdout bit", {15'd0, sdout}, {15'd0, exp_out[i]});
        end
        @(posedge sclk); #1;
        sdin = 1'b0;
        if (is_ctrl) begin
            if (!w[15] && addr < 7'd8) m_regs[addr[2:0]] = w[7:0];
            m_due = 1'b0;                                      // R5
            exp_stb = 1'b0;
        end else begin
            m_tx = hc ? w : {w[15:1], 1'b0};                   // R3 R4
            m_due = hc | w[0];
            exp_stb = 1'b1;
        end
        check("R2 tx_code_stb", {15'd0, tx_code_stb}, {15'd0, exp_stb});
        check(hc ? "R4 tx_code" : "R3 tx_code", tx_code, m_tx);
        check("R5 ctl_frame_due", {15'd0, ctl_frame_due}, {15'd0, m_due});
        check("R9 mode outputs", {14'd0, ctl_quarter_pos, hw_ctl_mode}, {14'd0, m_regs[1][1:0]});
        #2 check("R10 idle sdout", {15'd0, sdout}, 16'd0);
        @(posedge sclk); #1;
        check("R2 strobe one cycle", {15'd0, tx_code_stb}, 16'd0);
        #2 check("R10 idle sdout", {15'd0, sdout}, 16'd0);
        @(posedge sclk); #1;
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m_regs[i] = 8'h00;
        repeat (3) @(posedge sclk);
        #1 rst_n = 1'b1;
        #2;
        // R9 reset state
        check("R9 reset tx_code", tx_code, 16'h0000);
        check("R9 reset strobe/due", {14'd0, tx_code_stb, ctl_frame_due}, 16'd0);
        check("R9 reset mode outputs", {14'd0, ctl_quarter_pos, hw_ctl_mode}, 16'd0);
        check("R10 reset sdout", {15'd0, sdout}, 16'd0);
        @(posedge sclk); #1;
        frame(16'hA5A4, 16'h1234);   // R1 R2 data, no request
        frame(16'hBEEF, 16'hC3A1);   // R3 request, LSB cleared
        frame(16'h035A, 16'hFFFF);   // R6 write reg 3
        frame(16'h0001, 16'h8001);   // R3 request
        frame(16'h8300, 16'h7777);   // R7 read reg 3
        frame(16'h0001, 16'h0F0F);
        frame(16'h40FF, 16'h0000);   // R8 write unimplemented
        frame(16'h0001, 16'hAAAA);
        frame(16'hC000, 16'h5555);   // R8 read unimplemented
        frame(16'h0001, 16'h1111);
        frame(16'h8300, 16'h2222);   // R8 reg 3 untouched
        frame(16'h0001, 16'h3333);
        frame(16'h0781, 16'h4444);   // R6 write reg 7
        frame(16'h0001, 16'h6666);
        frame(16'h0103, 16'h9999);   // R9 hw mode + position bit
        frame(16'h1235, 16'hABCD);   // R4 all bits kept, due set
        frame(16'h8100, 16'hDCBA);   // R7 read reg 1
        frame(16'h1234, 16'hFEDC);   // R4 due set even with LSB 0
        frame(16'h8700, 16'h0102);   // R7 read reg 7
        frame(16'hFFFF, 16'h0304);
        frame(16'h0100, 16'h0506);   // back to software mode
        frame(16'h7776, 16'h0708);   // R3 no request
        frame(16'hFFFF, 16'h090A);   // R5 next is data
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule